// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Buffer

This block recovers asynchronous serial characters from a single input line. A strobe that pulses sixteen times per bit period paces the sampling. Each character has one start bit, five to eight data bits sent least-significant first, an optional parity bit and a stop bit. The block writes every character into a receive buffer as a 12-bit entry: the data byte plus four error flags for framing, parity, break and overrun.

The consumer reads the entry at the head of the buffer and pops it with a one-cycle strobe. Empty and full flags report the buffer's occupancy. A separate 4-bit status register follows the error flags of the most recently popped entry, except for its overrun bit, which is set at the moment a character is lost. A one-cycle clear strobe resets the status register. With buffering turned off, the buffer acts as a single holding register.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0 and `stat_o` is 0.
- R2: A falling edge on the line starts a character only if the line is still low at the eighth tick after detection. A shorter low pulse produces no entry.
- R3: Each data bit is sampled in the middle of its bit period and placed least-significant first into entry bits 7:0. `cfg_wlen_i` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper data bits read 0.
- R4: When `cfg_par_en_i` is 1, one parity bit follows the data and is checked. The expected value makes the count of ones even when `cfg_par_even_i` is 1 and odd when it is 0. When `cfg_par_stick_i` is 1, the expected value is instead the inverse of `cfg_par_even_i`. A mismatch sets entry bit 9. When `cfg_par_en_i` is 0, no parity bit is expected.
- R5: Only one stop bit is sampled. If it is low, entry bit 8 is set, unless the frame is a break. A new start bit may follow directly after a single stop bit.
- R6: A frame that is low from the start bit through the stop bit is a break. It produces exactly one entry, 0x400 (bit 10 only), and no further character is accepted until the line returns high. After a low stop bit, the receiver likewise waits for a high line.
- R7: A character that completes while the buffer is full is discarded, and `stat_o[3]` becomes 1 in the following cycle. The next entry that is stored carries bit 11.
- R8: Popping a non-empty buffer copies entry bits 10:8 of the popped entry into `stat_o[2:0]`. The bit order is framing, parity, break. `stat_o[3]` is unchanged by a pop.
- R9: A cycle with `stat_clr_i` high sets all four status bits to 0.
- R10: With `cfg_fifo_en_i` at 0, the buffer holds one entry and `full_o` rises after one character. With it at 1, the buffer holds `DEPTH` entries and returns them in arrival order.
- R11: While `rx_en_i` is 0, no new character starts. Dropping `rx_en_i` in the middle of a character still lets that character complete and be stored.
- R12: A pop strobe on an empty buffer changes neither the flags nor `stat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | Sampling strobe, 16 pulses per bit period |
| rx_en_i | input | 1 | Allows new characters to start |
| cfg_wlen_i | input | 2 | Data length code (00 gives 5 bits, 11 gives 8 bits) |
| cfg_par_en_i | input | 1 | Parity bit present and checked |
| cfg_par_even_i | input | 1 | Even parity when 1, odd when 0 |
| cfg_par_stick_i | input | 1 | Fixed parity value, the inverse of cfg_par_even_i |
| cfg_fifo_en_i | input | 1 | Multi-entry buffer when 1, one holding entry when 0 |
| pop_i | input | 1 | Removes the head entry |
| rd_data_o | output | 12 | Head entry: data 7:0, framing 8, parity 9, break 10, overrun 11 |
| empty_o | output | 1 | Buffer holds no entry |
| full_o | output | 1 | Buffer is at its capacity for the current mode |
| stat_clr_i | input | 1 | Clears the status register |
| stat_o | output | 4 | Status: framing 0, parity 1, break 2, overrun 3 |

## Verification
The assertions assume that `tick16_i` arrives as single-cycle pulses. They also assume that the buffering mode changes only while the buffer is empty, so a holding-register-mode buffer is full exactly when it is non-empty. The stimulus changes any configuration input only while the line is idle and the buffer has been drained. It drives the line in whole bit periods aligned to the strobe, so every mid-bit sample falls well inside a bit. The one deliberate exception is a short low pulse that ends before the start-bit check.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic       ovr;
    logic       brk;
    logic       par;
    logic       frm;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  // Expected parity bit value; data bits above the character length are zero.
  function automatic logic exp_parity(input logic [7:0] d, input logic even, input logic stick);
    if (stick) return ~even;
    return even ? (^d) : ~(^d);
  endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_i,
  input  logic      tick_i,
  input  logic      rx_en_i,
  input  logic [1:0] wlen_i,
  input  logic      par_en_i,
  input  logic      par_even_i,
  input  logic      par_stick_i,
  output logic      push_o,
  output rx_entry_t ent_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MIDC = CW'(OVS / 2 - 1);

  logic            rx_m, rx_s;
  rx_state_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [2:0]      bidx_q, bidx_d;
  logic [7:0]      sh_q, sh_d;
  logic            allz_q, allz_d;
  logic            pbad_q, pbad_d;
  logic [2:0]      last_idx;

  assign last_idx = 3'd4 + {1'b0, wlen_i};

  // Two-flop synchronizer on the line, idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
    end
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bidx_d = bidx_q;
    sh_d   = sh_q;
    allz_d = allz_q;
    pbad_d = pbad_q;
    push_o = 1'b0;
    if (tick_i) begin
      case (st_q)
        RX_IDLE: begin
          if (rx_en_i && !rx_s) begin
            st_d   = RX_START;
            cnt_d  = '0;
            bidx_d = '0;
            sh_d   = '0;
            allz_d = 1'b1;
            pbad_d = 1'b0;
          end
        end
        RX_START: begin
          if (cnt_q == MIDC) begin
            cnt_d = '0;
            st_d  = rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST) begin
            cnt_d        = '0;
            sh_d[bidx_q] = rx_s;
            allz_d       = allz_q & ~rx_s;
            if (bidx_q == last_idx) st_d = par_en_i ? RX_PAR : RX_STOP;
            else                    bidx_d = bidx_q + 3'd1;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        RX_PAR: begin
          if (cnt_q == LAST) begin
            cnt_d  = '0;
            pbad_d = (rx_s != exp_parity(sh_q, par_even_i, par_stick_i));
            allz_d = allz_q & ~rx_s;
            st_d   = RX_STOP;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST) begin
            push_o = 1'b1;
            cnt_d  = '0;
            st_d   = rx_s ? RX_IDLE : RX_HOLD;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        RX_HOLD: begin
          if (rx_s) st_d = RX_IDLE;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      allz_q <= 1'b0;
      pbad_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bidx_q <= bidx_d;
      sh_q   <= sh_d;
      allz_q <= allz_d;
      pbad_q <= pbad_d;
    end
  end

  // Flags as seen at the stop-bit sample
  always_comb begin
    ent_o.data = sh_q;
    ent_o.brk  = ~rx_s & allz_q;
    ent_o.frm  = ~rx_s & ~allz_q;
    ent_o.par  = pbad_q & ~(~rx_s & allz_q);
    ent_o.ovr  = 1'b0;
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fifo_en_i,
  input  logic      push_i,
  input  rx_entry_t ent_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic      empty_o,
  output logic      full_o,
  output logic      pop_ok_o,
  output logic      ovr_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic          pend_q, pend_d;
  logic          acc;
  rx_entry_t     wr_ent;

  assign cap      = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q >= cap);
  assign pop_ok_o = pop_i & ~empty_o;
  assign acc      = push_i & (~full_o | pop_ok_o);
  assign ovr_o    = push_i & ~acc;
  assign head_o   = mem[rd_q];

  always_comb begin
    wr_ent     = ent_i;
    wr_ent.ovr = pend_q;
    wr_d       = wr_q;
    rd_d       = rd_q;
    cnt_d      = cnt_q;
    pend_d     = pend_q;
    if (acc)      wr_d = (wr_q == PLAST) ? '0 : wr_q + AW'(1);
    if (pop_ok_o) rd_d = (rd_q == PLAST) ? '0 : rd_q + AW'(1);
    case ({acc, pop_ok_o})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
    if (ovr_o)    pend_d = 1'b1;
    else if (acc) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  // Storage array, written only on accepted pushes
  always_ff @(posedge clk) begin
    if (acc) mem[wr_q] <= wr_ent;
  end

endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pop_ok_i,
  input  logic [2:0] head_flags_i,
  input  logic       ovr_i,
  input  logic       clr_i,
  output logic [3:0] stat_o
);
  logic [3:0] stat_d;

  always_comb begin
    stat_d = stat_o;
    if (clr_i)    stat_d = '0;
    if (pop_ok_i) stat_d[2:0] = head_flags_i;
    if (ovr_i)    stat_d[3] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= stat_d;
  end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_i,
  input  logic        tick16_i,
  input  logic        rx_en_i,
  input  logic [1:0]  cfg_wlen_i,
  input  logic        cfg_par_en_i,
  input  logic        cfg_par_even_i,
  input  logic        cfg_par_stick_i,
  input  logic        cfg_fifo_en_i,
  input  logic        pop_i,
  output logic [11:0] rd_data_o,
  output logic        empty_o,
  output logic        full_o,
  input  logic        stat_clr_i,
  output logic [3:0]  stat_o
);
  logic      rst_m, rst_s;
  logic      samp_push;
  rx_entry_t samp_ent;
  rx_entry_t head;
  logic      pop_ok;
  logic      fifo_ovr;

  // Reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  uart_rx_sampler #(.OVS(OVS)) u_samp (
    .clk         (clk),
    .rst_n       (rst_s),
    .rx_i        (rx_i),
    .tick_i      (tick16_i),
    .rx_en_i     (rx_en_i),
    .wlen_i      (cfg_wlen_i),
    .par_en_i    (cfg_par_en_i),
    .par_even_i  (cfg_par_even_i),
    .par_stick_i (cfg_par_stick_i),
    .push_o      (samp_push),
    .ent_o       (samp_ent)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_s),
    .fifo_en_i (cfg_fifo_en_i),
    .push_i    (samp_push),
    .ent_i     (samp_ent),
    .pop_i     (pop_i),
    .head_o    (head),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .pop_ok_o  (pop_ok),
    .ovr_o     (fifo_ovr)
  );

  uart_rx_stat u_stat (
    .clk          (clk),
    .rst_n        (rst_s),
    .pop_ok_i     (pop_ok),
    .head_flags_i ({head.brk, head.par, head.frm}),
    .ovr_i        (fifo_ovr),
    .clr_i        (stat_clr_i),
    .stat_o       (stat_o)
  );

  assign rd_data_o = head;

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_fifo_en_i,
  input logic        pop_i,
  input logic [11:0] rd_data_o,
  input logic        empty_o,
  input logic        full_o,
  input logic        stat_clr_i,
  input logic [3:0]  stat_o,
  input logic        samp_push,
  input logic        fifo_ovr
);

  // R1: empty and full never hold together
  a_r1_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_o && full_o));

  // R10: holding-register mode is full whenever occupied
  a_r10_hold_single: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fifo_en_i && !empty_o) |-> full_o);

  // R7: a lost character shows in status on the next cycle
  a_r7_ovr_now: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovr |=> stat_o[3]);

  // R7: overrun status stays until cleared
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[3] && !stat_clr_i) |=> stat_o[3]);

  // R9: clear without competing updates empties status
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_i && !pop_i && !fifo_ovr) |=> (stat_o == 4'h0));

  // R8: pop copies the popped entry's error bits
  a_r8_pop_update: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_o) |=> (stat_o[2:0] == $past(rd_data_o[10:8])));

  // R12: with no pop of a real entry, no clear and no overrun, status holds
  a_r12_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pop_i && !empty_o) && !stat_clr_i && !fifo_ovr) |=> $stable(stat_o));

  // R5: one stop sample gives one push pulse
  a_r5_single_push: assert property (@(posedge clk) disable iff (!rst_n)
    samp_push |=> !samp_push);

endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_fifo_en_i (cfg_fifo_en_i),
  .pop_i         (pop_i),
  .rd_data_o     (rd_data_o),
  .empty_o       (empty_o),
  .full_o        (full_o),
  .stat_clr_i    (stat_clr_i),
  .stat_o        (stat_o),
  .samp_push     (samp_push),
  .fifo_ovr      (fifo_ovr)
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
  localparam int DEPTH = 4;
  localparam int BITCLK = 32; // 16 ticks, one every two clocks

  logic        clk;
  logic        rst_n;
  logic        rx_i, tick16_i, rx_en_i;
  logic [1:0]  cfg_wlen_i;
  logic        cfg_par_en_i, cfg_par_even_i, cfg_par_stick_i, cfg_fifo_en_i;
  logic        pop_i, stat_clr_i;
  logic [11:0] rd_data_o;
  logic        empty_o, full_o;
  logic [3:0]  stat_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  uart_rx_core #(.OVS(16), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick16_i(tick16_i), .rx_en_i(rx_en_i),
    .cfg_wlen_i(cfg_wlen_i), .cfg_par_en_i(cfg_par_en_i), .cfg_par_even_i(cfg_par_even_i),
    .cfg_par_stick_i(cfg_par_stick_i), .cfg_fifo_en_i(cfg_fifo_en_i), .pop_i(pop_i),
    .rd_data_o(rd_data_o), .empty_o(empty_o), .full_o(full_o),
    .stat_clr_i(stat_clr_i), .stat_o(stat_o)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    tick16_i = 1'b0;
    forever begin
      @(negedge clk);
      tick16_i = ~tick16_i;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input int nb, input logic even, input logic stick);
    logic [7:0] m;
    m = d & 8'((1 << nb) - 1);
    if (stick) return ~even;
    return even ? ^m : ~(^m);
  endfunction

  task automatic line_idle(input int nbits);
    rx_i = 1'b1;
    repeat (nbits * BITCLK) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input int nb, input bit use_par,
                           input logic pbit, input logic stopv);
    rx_i = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_i = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (use_par) begin
      rx_i = pbit;
      repeat (BITCLK) @(negedge clk);
    end
    rx_i = stopv;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic do_pop(output logic [11:0] got);
    got   = rd_data_o;
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clr();
    stat_clr_i = 1'b1;
    @(negedge clk);
    stat_clr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_pop(input string req, input logic [11:0] exp);
    logic [11:0] got;
    check({req, " entry present"}, 32'(empty_o), 32'd0);
    do_pop(got);
    check(req, 32'(got), 32'(exp));
  endtask

  task automatic set_cfg(input logic [1:0] w, input logic pe, input logic ev, input logic st, input logic fe);
    cfg_wlen_i = w; cfg_par_en_i = pe; cfg_par_even_i = ev; cfg_par_stick_i = st; cfg_fifo_en_i = fe;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 empty", 32'(empty_o), 32'd1);
    check("R1 full", 32'(full_o), 32'd0);
    check("R1 status", 32'(stat_o), 32'd0);
  endtask

  task automatic t_lengths();
    set_cfg(2'b11, 0, 0, 0, 1);
    send_char(8'hA5, 8, 0, 0, 1); line_idle(1);
    expect_pop("R3 8-bit", 12'h0A5);
    check("R8 clean status", 32'(stat_o), 32'd0);
    set_cfg(2'b00, 0, 0, 0, 1);
    send_char(8'h1F, 5, 0, 0, 1); line_idle(1);
    expect_pop("R3 5-bit", 12'h01F);
    set_cfg(2'b01, 0, 0, 0, 1);
    send_char(8'h2C, 6, 0, 0, 1); line_idle(1);
    expect_pop("R3 6-bit", 12'h02C);
    set_cfg(2'b10, 0, 0, 0, 1);
    send_char(8'h5A, 7, 0, 0, 1); line_idle(1);
    expect_pop("R3 7-bit", 12'h05A);
  endtask

  task automatic t_parity();
    set_cfg(2'b11, 1, 1, 0, 1);
    send_char(8'h03, 8, 1, par_bit(8'h03, 8, 1, 0), 1); line_idle(1);
    expect_pop("R4 even good", 12'h003);
    send_char(8'h03, 8, 1, ~par_bit(8'h03, 8, 1, 0), 1); line_idle(1);
    expect_pop("R4 even bad", 12'h203);
    check("R8 parity status", 32'(stat_o), 32'h2);
    do_clr();
    set_cfg(2'b11, 1, 0, 0, 1);
    send_char(8'h07, 8, 1, par_bit(8'h07, 8, 0, 0), 1); line_idle(1);
    expect_pop("R4 odd good", 12'h007);
    set_cfg(2'b11, 1, 1, 1, 1);
    send_char(8'h80, 8, 1, 1'b1, 1); line_idle(1);
    expect_pop("R4 stick zero", 12'h280);
    set_cfg(2'b11, 1, 0, 1, 1);
    send_char(8'h81, 8, 1, 1'b1, 1); line_idle(1);
    expect_pop("R4 stick one", 12'h081);
    do_clr();
    set_cfg(2'b11, 0, 0, 0, 1);
  endtask

  task automatic t_framing();
    logic [11:0] got;
    send_char(8'h55, 8, 0, 0, 0); line_idle(1);
    expect_pop("R5 framing", 12'h155);
    check("R8 framing status", 32'(stat_o), 32'h1);
    do_pop(got);
    check("R12 pop empty flags", 32'(empty_o), 32'd1);
    check("R12 pop empty status", 32'(stat_o), 32'h1);
    do_clr();
    check("R9 clear", 32'(stat_o), 32'h0);
    send_char(8'h3C, 8, 0, 0, 1);
    send_char(8'hC3, 8, 0, 0, 1);
    line_idle(1);
    expect_pop("R5 back-to-back first", 12'h03C);
    expect_pop("R5 back-to-back second", 12'h0C3);
  endtask

  task automatic t_break();
    rx_i = 1'b0;
    repeat (12 * BITCLK) @(negedge clk);
    line_idle(2);
    expect_pop("R6 break entry", 12'h400);
    check("R6 single entry", 32'(empty_o), 32'd1);
    check("R8 break status", 32'(stat_o), 32'h4);
    do_clr();
  endtask

  task automatic t_glitch();
    rx_i = 1'b0;
    repeat (8) @(negedge clk);
    line_idle(3);
    check("R2 glitch ignored", 32'(empty_o), 32'd1);
  endtask

  task automatic t_overrun();
    set_cfg(2'b11, 0, 0, 0, 0);
    send_char(8'h61, 8, 0, 0, 1); line_idle(1);
    check("R10 hold full", 32'(full_o), 32'd1);
    send_char(8'h62, 8, 0, 0, 1); line_idle(1);
    check("R7 status set before read", 32'(stat_o[3]), 32'd1);
    expect_pop("R7 kept entry", 12'h061);
    send_char(8'h63, 8, 0, 0, 1); line_idle(1);
    expect_pop("R7 next entry flagged", 12'h863);
    check("R8 pop keeps overrun", 32'(stat_o[3]), 32'd1);
    do_clr();
    check("R9 overrun cleared", 32'(stat_o), 32'h0);
  endtask

  task automatic t_fifo();
    set_cfg(2'b11, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) send_char(8'(8'h11 * (i + 1)), 8, 0, 0, 1);
    line_idle(1);
    check("R10 fifo full", 32'(full_o), 32'd1);
    for (int i = 0; i < DEPTH; i++) expect_pop("R10 fifo order", 12'(8'h11 * (i + 1)));
    check("R10 fifo drained", 32'(empty_o), 32'd1);
  endtask

  task automatic t_rxen();
    rx_en_i = 1'b0;
    send_char(8'h5E, 8, 0, 0, 1); line_idle(1);
    check("R11 disabled ignores", 32'(empty_o), 32'd1);
    rx_en_i = 1'b1;
    fork
      begin send_char(8'hE7, 8, 0, 0, 1); line_idle(1); end
      begin repeat (100) @(negedge clk); rx_en_i = 1'b0; end
    join
    expect_pop("R11 mid-character completes", 12'h0E7);
    rx_en_i = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; rx_i = 1'b1; rx_en_i = 1'b1; pop_i = 1'b0; stat_clr_i = 1'b0;
    cfg_wlen_i = 2'b11; cfg_par_en_i = 1'b0; cfg_par_even_i = 1'b0;
    cfg_par_stick_i = 1'b0; cfg_fifo_en_i = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lengths();
    t_parity();
    t_framing();
    t_break();
    t_glitch();
    t_overrun();
    t_fifo();
    t_rxen();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule